// File: doc/BRIEF.md
# Nested-Loop DMA Channel Engine

This block is one DMA channel. A small register-style port loads a transfer descriptor: source and destination addresses, access sizes, signed per-beat steps, the minor-loop byte count, the major-loop iteration count, an optional signed rewind applied to the source after each minor loop, and two end-of-major-loop corrections. Each service request, from software or from a FIFO level compared against a watermark, runs one minor loop and then waits. A minor loop is a series of memory reads and writes through a single master port. All data passes through an internal byte buffer, so reads and writes never overlap.

The channel updates addresses at three levels. Each beat applies its own step. The end of each minor loop can apply a source rewind. The final iteration applies the last-address corrections and reloads the iteration count. Because of this, a well-programmed descriptor can be triggered again and again without being rewritten. A pulse of `done` marks the end of the major loop, and the flag stays high until the next accepted request.

Top module: `dma_nested_chan`

## Requirements
- R1: Each accepted request moves exactly the programmed minor-loop byte count (register 5) and then returns to idle; `busy` is high from the cycle after acceptance until the loop ends.
- R2: Access sizes are coded in register 4, source in bits [1:0] and destination in bits [3:2], as 0 = 1 byte, 1 = 2 bytes, 2 = 4 bytes. Every read carries the source code on `mem_size` and every write carries the destination code.
- R3: After each read the source address moves by the signed value in register 2. After each write the destination address moves by the signed value in register 3.
- R4: When bit 0 of register 8 is set, the signed value in register 7 is added to the source address at the end of every minor loop.
- R5: The source correction (register 9) and the destination correction (register 10) are added only when the final major iteration ends. At that point the iteration count reloads from the value last written to register 6.
- R6: Read bytes enter a holding buffer in little-endian order, and write beats drain the same byte sequence. The byte stream is kept when the read and write sizes differ.
- R7: `done` rises when a major loop completes, is never high while `busy` is high, and is cleared by the next accepted request. The channel restarts without any descriptor rewrite.
- R8: A request is rejected when the byte count is zero, is not a multiple of both access sizes, uses size code 3, or the iteration count is zero. A rejected request makes no memory access and sets `cfg_err`, which clears on the next descriptor write.
- R9: A software request that arrives while a minor loop runs is held and served right after that loop ends.
- R10: With bit 16 of register 11 set, a minor loop starts whenever `hw_level` exceeds the watermark in register 11 bits [7:0]. A watermark of 11 starts at 12 entries and not at 11.
- R11: After reset `busy`, `done`, `cfg_err` and `mem_req` are low.
- R12: Once `mem_req` is raised it stays high, with the same address and direction, until `mem_ack` arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Descriptor register write strobe |
| cfg_addr | input | 4 | Descriptor register index |
| cfg_wdata | input | 32 | Descriptor write data |
| sw_req | input | 1 | Software service request |
| hw_level | input | LVL_W | Fill level of the requesting FIFO |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_addr | output | ADDR_W | Byte address of the access |
| mem_size | output | 2 | Access size code |
| mem_wdata | output | 32 | Write data, low bytes used |
| mem_rdata | input | 32 | Read data, valid with ack |
| mem_ack | input | 1 | Access completion |
| busy | output | 1 | Minor loop in progress |
| done | output | 1 | Major loop finished |
| cfg_err | output | 1 | Last request rejected |

## Verification
Bad address state first shows up on `mem_addr` at the next beat after the faulty update. A wrong minor-loop rewind or last-address correction appears at the first write of the following request, because the write lands at a shifted destination or carries bytes from a different source window. Buffer ordering faults appear as wrong byte lanes on the very write that drains them. Counter faults show as `done` rising one request early or late.

// File: rtl/dma_chan_pkg.sv
package dma_chan_pkg;

   typedef enum logic [1:0] {
      ST_IDLE,
      ST_READ,
      ST_WRITE,
      ST_CLOSE
   } dma_state_e;

   localparam logic [3:0] REG_SRC_ADDR  = 4'd0;
   localparam logic [3:0] REG_DST_ADDR  = 4'd1;
   localparam logic [3:0] REG_SRC_STEP  = 4'd2;
   localparam logic [3:0] REG_DST_STEP  = 4'd3;
   localparam logic [3:0] REG_SIZES     = 4'd4;
   localparam logic [3:0] REG_MINOR_LEN = 4'd5;
   localparam logic [3:0] REG_MAJOR_CNT = 4'd6;
   localparam logic [3:0] REG_MINOR_ADJ = 4'd7;
   localparam logic [3:0] REG_ADJ_CTRL  = 4'd8;
   localparam logic [3:0] REG_SRC_LAST  = 4'd9;
   localparam logic [3:0] REG_DST_LAST  = 4'd10;
   localparam logic [3:0] REG_HW_TRIG   = 4'd11;

   function automatic logic [2:0] size_bytes(input logic [1:0] code);
      case (code)
         2'd0:    return 3'd1;
         2'd1:    return 3'd2;
         2'd2:    return 3'd4;
         default: return 3'd0;
      endcase
   endfunction

endpackage

// File: rtl/dma_hold_buf.sv
module dma_hold_buf #(
   parameter int unsigned DEPTH = 8,
   localparam int unsigned LW = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clear,
   input  logic          push,
   input  logic [2:0]    push_n,
   input  logic [31:0]   push_data,
   input  logic          pop,
   input  logic [2:0]    pop_n,
   output logic [31:0]   front,
   output logic [LW-1:0] level
);

   logic [7:0]    byte_q [DEPTH];
   logic [LW-1:0] lvl_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lvl_q <= '0;
         for (int i = 0; i < int'(DEPTH); i++) byte_q[i] <= 8'h00;
      end else if (clear) begin
         lvl_q <= '0;
      end else if (push) begin
         for (int i = 0; i < 4; i++) begin
            if (i < int'(push_n) && int'(lvl_q) + i < int'(DEPTH))
               byte_q[int'(lvl_q) + i] <= push_data[8*i +: 8];
         end
         lvl_q <= lvl_q + LW'(push_n);
      end else if (pop) begin
         for (int i = 0; i < int'(DEPTH); i++) begin
            byte_q[i] <= (i + int'(pop_n) < int'(DEPTH)) ? byte_q[i + int'(pop_n)] : 8'h00;
         end
         lvl_q <= lvl_q - LW'(pop_n);
      end
   end

   for (genvar g = 0; g < 4; g++) begin : g_front
      assign front[8*g +: 8] = byte_q[g];
   end

   assign level = lvl_q;

   AST_BUF_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      push |-> (int'(lvl_q) + int'(push_n) <= int'(DEPTH)));  // R6
   AST_BUF_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
      pop |-> (int'(lvl_q) >= int'(pop_n)));  // R6

endmodule

// File: rtl/dma_addr_reg.sv
module dma_addr_reg #(
   parameter int unsigned ADDR_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [ADDR_W-1:0] load_val,
   input  logic              step_en,
   input  logic [ADDR_W-1:0] step,
   input  logic              adj_en,
   input  logic [ADDR_W-1:0] adj,
   output logic [ADDR_W-1:0] addr
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       addr <= '0;
      else if (load)    addr <= load_val;
      else if (step_en) addr <= addr + step;
      else if (adj_en)  addr <= addr + adj;
   end

endmodule

// File: rtl/dma_iter_ctr.sv
module dma_iter_ctr #(
   parameter int unsigned CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   input  logic             dec,
   output logic [CNT_W-1:0] cur,
   output logic             last
);

   logic [CNT_W-1:0] beg_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         beg_q <= '0;
         cur   <= '0;
      end else if (load) begin
         beg_q <= load_val;
         cur   <= load_val;
      end else if (dec) begin
         cur <= last ? beg_q : cur - 1'b1;
      end
   end

   assign last = (cur == CNT_W'(1));

   AST_ITER_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
      dec |-> (cur != '0));  // R5

endmodule

// File: rtl/dma_nested_chan.sv
module dma_nested_chan
   import dma_chan_pkg::*;
#(
   parameter int unsigned ADDR_W        = 32,
   parameter int unsigned CNT_W         = 10,
   parameter int unsigned MB_W          = 12,
   parameter int unsigned LVL_W         = 8,
   parameter int unsigned BUF_BYTES     = 8,
   parameter bit          HAS_MINOR_ADJ = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_we,
   input  logic [3:0]        cfg_addr,
   input  logic [31:0]       cfg_wdata,
   input  logic              sw_req,
   input  logic [LVL_W-1:0]  hw_level,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [1:0]        mem_size,
   output logic [31:0]       mem_wdata,
   input  logic [31:0]       mem_rdata,
   input  logic              mem_ack,
   output logic              busy,
   output logic              done,
   output logic              cfg_err
);

   localparam int unsigned LEV_W = $clog2(BUF_BYTES + 1);

   if (BUF_BYTES < 8) begin : g_chk_buf
      $error("BUF_BYTES must hold two widest beats");
   end
   if (ADDR_W < 8 || ADDR_W > 32) begin : g_chk_addr
      $error("ADDR_W out of range");
   end
   if (MB_W < 3 || MB_W > 32 || CNT_W > 32 || LVL_W > 16) begin : g_chk_cnt
      $error("counter width out of range");
   end

   // descriptor storage
   logic [ADDR_W-1:0] src_step_q, dst_step_q, madj_q, slast_q, dlast_q;
   logic [1:0]        ss_code_q, ds_code_q;
   logic [MB_W-1:0]   mb_q;
   logic              madj_en_q;
   logic [LVL_W-1:0]  wm_q;
   logic              hw_en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_step_q <= '0;
         dst_step_q <= '0;
         madj_q     <= '0;
         slast_q    <= '0;
         dlast_q    <= '0;
         ss_code_q  <= '0;
         ds_code_q  <= '0;
         mb_q       <= '0;
         madj_en_q  <= 1'b0;
         wm_q       <= '0;
         hw_en_q    <= 1'b0;
      end else if (cfg_we) begin
         case (cfg_addr)
            REG_SRC_STEP:  src_step_q <= cfg_wdata[ADDR_W-1:0];
            REG_DST_STEP:  dst_step_q <= cfg_wdata[ADDR_W-1:0];
            REG_SIZES: begin
               ss_code_q <= cfg_wdata[1:0];
               ds_code_q <= cfg_wdata[3:2];
            end
            REG_MINOR_LEN: mb_q      <= cfg_wdata[MB_W-1:0];
            REG_MINOR_ADJ: madj_q    <= cfg_wdata[ADDR_W-1:0];
            REG_ADJ_CTRL:  madj_en_q <= cfg_wdata[0];
            REG_SRC_LAST:  slast_q   <= cfg_wdata[ADDR_W-1:0];
            REG_DST_LAST:  dlast_q   <= cfg_wdata[ADDR_W-1:0];
            REG_HW_TRIG: begin
               wm_q    <= cfg_wdata[LVL_W-1:0];
               hw_en_q <= cfg_wdata[16];
            end
            default: ;
         endcase
      end
   end

   // control
   dma_state_e        st_q, st_d;
   logic [MB_W-1:0]   left_q;
   logic              pend_q, done_q, err_q;
   logic [2:0]        ss_b, ds_b;
   logic [CNT_W-1:0]  iter_cur;
   logic              iter_last;
   logic [LEV_W-1:0]  buf_lvl;
   logic              cfg_ok, hw_fire, go, accept, reject;
   logic              rd_done, wr_done, closing;
   logic [ADDR_W-1:0] src_addr, dst_addr, src_close_adj, dst_close_adj, minor_adj;

   assign ss_b    = size_bytes(ss_code_q);
   assign ds_b    = size_bytes(ds_code_q);
   assign cfg_ok  = (ss_b != 3'd0) && (ds_b != 3'd0) && (mb_q != '0) &&
                    ((mb_q & MB_W'(ss_b - 3'd1)) == '0) &&
                    ((mb_q & MB_W'(ds_b - 3'd1)) == '0) &&
                    (iter_cur != '0);
   assign hw_fire = hw_en_q && (hw_level > wm_q);
   assign go      = sw_req || pend_q || hw_fire;
   assign accept  = (st_q == ST_IDLE) && go && cfg_ok;
   assign reject  = (st_q == ST_IDLE) && go && !cfg_ok;
   assign rd_done = (st_q == ST_READ) && mem_ack;
   assign wr_done = (st_q == ST_WRITE) && mem_ack;
   assign closing = (st_q == ST_CLOSE);

   always_comb begin
      st_d = st_q;
      case (st_q)
         ST_IDLE:  if (accept) st_d = ST_READ;
         ST_READ: begin
            if (mem_ack)
               st_d = (int'(buf_lvl) + int'(ss_b) >= int'(ds_b)) ? ST_WRITE : ST_READ;
         end
         ST_WRITE: begin
            if (mem_ack) begin
               if (left_q == MB_W'(ds_b))
                  st_d = ST_CLOSE;
               else if (int'(buf_lvl) - int'(ds_b) >= int'(ds_b))
                  st_d = ST_WRITE;
               else
                  st_d = ST_READ;
            end
         end
         default:  st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         left_q <= '0;
         pend_q <= 1'b0;
         done_q <= 1'b0;
         err_q  <= 1'b0;
      end else begin
         st_q <= st_d;
         if (accept)       left_q <= mb_q;
         else if (wr_done) left_q <= left_q - MB_W'(ds_b);
         if (st_q != ST_IDLE && sw_req)  pend_q <= 1'b1;
         else if (st_q == ST_IDLE && go) pend_q <= 1'b0;
         if (accept)                      done_q <= 1'b0;
         else if (closing && iter_last)   done_q <= 1'b1;
         if (cfg_we)      err_q <= 1'b0;
         else if (reject) err_q <= 1'b1;
      end
   end

   // minor-loop rewind variant
   if (HAS_MINOR_ADJ) begin : g_madj
      assign minor_adj = madj_en_q ? madj_q : '0;
   end else begin : g_no_madj
      assign minor_adj = '0;
   end

   assign src_close_adj = minor_adj + (iter_last ? slast_q : '0);
   assign dst_close_adj = iter_last ? dlast_q : '0;

   dma_addr_reg #(.ADDR_W(ADDR_W)) u_src (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (cfg_we && cfg_addr == REG_SRC_ADDR),
      .load_val (cfg_wdata[ADDR_W-1:0]),
      .step_en  (rd_done),
      .step     (src_step_q),
      .adj_en   (closing),
      .adj      (src_close_adj),
      .addr     (src_addr)
   );

   dma_addr_reg #(.ADDR_W(ADDR_W)) u_dst (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (cfg_we && cfg_addr == REG_DST_ADDR),
      .load_val (cfg_wdata[ADDR_W-1:0]),
      .step_en  (wr_done),
      .step     (dst_step_q),
      .adj_en   (closing),
      .adj      (dst_close_adj),
      .addr     (dst_addr)
   );

   dma_iter_ctr #(.CNT_W(CNT_W)) u_iter (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (cfg_we && cfg_addr == REG_MAJOR_CNT),
      .load_val (cfg_wdata[CNT_W-1:0]),
      .dec      (closing),
      .cur      (iter_cur),
      .last     (iter_last)
   );

   dma_hold_buf #(.DEPTH(BUF_BYTES)) u_buf (
      .clk       (clk),
      .rst_n     (rst_n),
      .clear     (accept),
      .push      (rd_done),
      .push_n    (ss_b),
      .push_data (mem_rdata),
      .pop       (wr_done),
      .pop_n     (ds_b),
      .front     (mem_wdata),
      .level     (buf_lvl)
   );

   assign mem_req  = (st_q == ST_READ) || (st_q == ST_WRITE);
   assign mem_we   = (st_q == ST_WRITE);
   assign mem_addr = (st_q == ST_WRITE) ? dst_addr : src_addr;
   assign mem_size = (st_q == ST_WRITE) ? ds_code_q : ss_code_q;
   assign busy     = (st_q != ST_IDLE);
   assign done     = done_q;
   assign cfg_err  = err_q;

   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));  // R12
   AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);  // R7
   AST_ERR_NO_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cfg_err) |-> !mem_req);  // R8
   AST_PEND_SERVED: assert property (@(posedge clk) disable iff (!rst_n)
      (closing && pend_q) |=> ##1 (busy || cfg_err));  // R9

endmodule

// File: tb/tb_dma_nested_chan.sv
module tb_dma_nested_chan;

   typedef struct {
      logic [31:0] addr;
      logic [1:0]  size;
      logic [31:0] data;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 1'b0;
   logic [3:0]  cfg_addr = '0;
   logic [31:0] cfg_wdata = '0;
   logic        sw_req = 1'b0;
   logic [7:0]  hw_level = '0;
   logic        mem_req, mem_we, busy, done, cfg_err;
   logic [31:0] mem_addr, mem_wdata, mem_rdata;
   logic [1:0]  mem_size;
   logic        ack = 1'b0;

   always #10 clk = ~clk;

   dma_nested_chan dut (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .sw_req(sw_req), .hw_level(hw_level), .mem_req(mem_req), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_size(mem_size), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .mem_ack(ack), .busy(busy), .done(done), .cfg_err(cfg_err)
   );

   logic [7:0]  mem [0:4095];
   logic [11:0] ra;
   assign ra = mem_addr[11:0];
   assign mem_rdata = {mem[ra + 12'd3], mem[ra + 12'd2], mem[ra + 12'd1], mem[ra]};

   always @(posedge clk) ack <= rst_n ? (mem_req && !ack) : 1'b0;

   int   checks = 0;
   int   fails = 0;
   exp_t q[$];
   logic [1:0]  exp_rsize = '0;
   bit          saw_busy = 0;
   bit          hold_wait = 0;
   logic [31:0] hold_addr = '0;

   // model of the descriptor
   logic [31:0] m_src, m_dst, m_soff, m_doff, m_madj, m_slast, m_dlast;
   int          m_ss, m_ds, m_mb, m_cnt, m_beg;
   bit          m_men;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   function automatic int nb(input int code);
      return 1 << code;
   endfunction

   // monitor: scoreboard pop and bus protocol
   always @(negedge clk) begin
      if (rst_n) begin
         exp_t        e;
         logic [31:0] mask;
         if (busy) saw_busy = 1;
         if (hold_wait) chk(mem_req && mem_addr == hold_addr, "R12 request held", mem_addr, hold_addr);
         hold_wait = mem_req && !ack;
         hold_addr = mem_addr;
         if (mem_req && ack) begin
            if (!mem_we) begin
               chk(mem_size == exp_rsize, "R2 read size", 32'(mem_size), 32'(exp_rsize));
            end else if (q.size() == 0) begin
               chk(0, "R1 unexpected write", mem_addr, 32'h0);
            end else begin
               e = q.pop_front();
               mask = (e.size == 2'd2) ? 32'hFFFF_FFFF : (e.size == 2'd1) ? 32'h0000_FFFF : 32'h0000_00FF;
               chk(mem_addr == e.addr, "R3 write address", mem_addr, e.addr);
               chk(mem_size == e.size && (mem_wdata & mask) == e.data, "R6 write data",
                   mem_wdata & mask, e.data);
               for (int k = 0; k < nb(int'(mem_size)); k++)
                  mem[ra + 12'(k)] = mem_wdata[8*k +: 8];
            end
         end
      end
   end

   task automatic cfg_wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic setup(input logic [31:0] s, input logic [31:0] d, input int ssc, input int dsc,
                        input int so, input int dof, input int mbv, input int cnt,
                        input bit men, input int madj, input int sl, input int dl);
      cfg_wr(4'd0, s);
      cfg_wr(4'd1, d);
      cfg_wr(4'd2, 32'(so));
      cfg_wr(4'd3, 32'(dof));
      cfg_wr(4'd4, 32'((dsc << 2) | ssc));
      cfg_wr(4'd5, 32'(mbv));
      cfg_wr(4'd6, 32'(cnt));
      cfg_wr(4'd7, 32'(madj));
      cfg_wr(4'd8, {31'b0, men});
      cfg_wr(4'd9, 32'(sl));
      cfg_wr(4'd10, 32'(dl));
      m_src = s; m_dst = d; m_ss = ssc; m_ds = dsc; m_soff = 32'(so); m_doff = 32'(dof);
      m_mb = mbv; m_cnt = cnt; m_beg = cnt; m_men = men; m_madj = 32'(madj);
      m_slast = 32'(sl); m_dlast = 32'(dl);
      exp_rsize = 2'(ssc);
   endtask

   // driver side: predict one minor loop into the scoreboard
   task automatic predict_minor(output bit last);
      logic [7:0]  st[$];
      logic [31:0] dat;
      exp_t        e;
      for (int r = 0; r < m_mb / nb(m_ss); r++) begin
         for (int k = 0; k < nb(m_ss); k++) st.push_back(mem[12'(m_src + 32'(k))]);
         m_src = m_src + m_soff;
      end
      for (int w = 0; w < m_mb / nb(m_ds); w++) begin
         dat = '0;
         for (int k = 0; k < nb(m_ds); k++) dat[8*k +: 8] = st[w * nb(m_ds) + k];
         e.addr = m_dst; e.size = 2'(m_ds); e.data = dat;
         q.push_back(e);
         m_dst = m_dst + m_doff;
      end
      if (m_men) m_src = m_src + m_madj;
      m_cnt--;
      last = 0;
      if (m_cnt == 0) begin
         m_src = m_src + m_slast;
         m_dst = m_dst + m_dlast;
         m_cnt = m_beg;
         last = 1;
      end
   endtask

   task automatic sw_pulse();
      @(negedge clk);
      sw_req = 1'b1;
      @(negedge clk);
      sw_req = 1'b0;
   endtask

   task automatic wait_drain();
      int n = 0;
      while ((busy || q.size() != 0) && n < 3000) begin
         @(negedge clk);
         n++;
      end
      @(negedge clk);
   endtask

   task automatic run_one(input string tag);
      bit last;
      predict_minor(last);
      sw_pulse();
      chk(busy == 1'b1, "R1 busy after request", 32'(busy), 32'h1);
      chk(done == 1'b0, "R7 done cleared by request", 32'(done), 32'h0);
      wait_drain();
      chk(q.size() == 0, "R1 minor loop byte count", 32'(q.size()), 32'h0);
      chk(done == last, {"R5 done at major end ", tag}, 32'(done), 32'(last));
   endtask

   initial begin
      for (int i = 0; i < 4096; i++) mem[i] = 8'((i * 13 + 7) & 255);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R11 reset state
      chk(busy == 1'b0 && mem_req == 1'b0, "R11 reset idle", {30'b0, busy, mem_req}, 32'h0);
      chk(done == 1'b0 && cfg_err == 1'b0, "R11 reset flags", {30'b0, done, cfg_err}, 32'h0);

      // R4/R5/R7: 16-byte window re-read three times into 48 bytes
      setup(32'h100, 32'h800, 1, 1, 2, 2, 16, 3, 1'b1, -16, 0, -48);
      run_one("iter1");
      run_one("iter2");
      chk(mem[12'h810] == mem[12'h800] && mem[12'h81F] == mem[12'h80F],
          "R4 source window rewound", {24'b0, mem[12'h810]}, {24'b0, mem[12'h800]});
      run_one("iter3");
      // R7 restart without rewriting descriptor
      run_one("restart");

      // R2/R6: byte reads into word writes
      setup(32'h140, 32'h900, 0, 2, 1, 4, 8, 1, 1'b0, 0, -8, -8);
      run_one("bytes-to-words");
      run_one("bytes-to-words again");

      // R3/R9: word reads with negative step, byte writes with gaps, pending request
      setup(32'h180, 32'hA00, 2, 0, -4, 2, 8, 2, 1'b0, 0, 16, 0);
      begin
         bit l1, l2;
         predict_minor(l1);
         predict_minor(l2);
         sw_pulse();
         repeat (2) @(negedge clk);
         chk(busy == 1'b1, "R9 still busy at second request", 32'(busy), 32'h1);
         sw_pulse();
         wait_drain();
         chk(q.size() == 0, "R9 pending request served", 32'(q.size()), 32'h0);
         chk(done == l2, "R9 both loops ran to major end", 32'(done), 32'(l2));
      end

      // R8: byte count 6 is not a multiple of 4-byte writes
      setup(32'h1A0, 32'hA80, 1, 2, 2, 4, 6, 1, 1'b0, 0, 0, 0);
      saw_busy = 0;
      sw_pulse();
      repeat (5) @(negedge clk);
      chk(cfg_err == 1'b1, "R8 error raised", 32'(cfg_err), 32'h1);
      chk(saw_busy == 0 && q.size() == 0, "R8 request ignored", 32'(saw_busy), 32'h0);
      cfg_wr(4'd5, 32'd8);
      chk(cfg_err == 1'b0, "R8 error cleared by write", 32'(cfg_err), 32'h0);

      // R10: watermark 11, enable bit 16
      setup(32'h1C0, 32'hB00, 2, 2, 4, 4, 12, 1, 1'b0, 0, -12, -12);
      cfg_wr(4'd11, 32'h0001_000B);
      hw_level = 8'd11;
      saw_busy = 0;
      repeat (20) @(negedge clk);
      chk(saw_busy == 0, "R10 no start at watermark", 32'(saw_busy), 32'h0);
      begin
         bit l;
         int n = 0;
         predict_minor(l);
         hw_level = 8'd12;
         while (!busy && n < 50) begin
            @(negedge clk);
            n++;
         end
         hw_level = 8'd0;
         chk(busy == 1'b1, "R10 start above watermark", 32'(busy), 32'h1);
         wait_drain();
         chk(q.size() == 0, "R10 one minor loop", 32'(q.size()), 32'h0);
         chk(done == l, "R10 done after single iteration", 32'(done), 32'(l));
      end
      cfg_wr(4'd11, 32'h0);

      $display("test done: total=%0d bad=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      fails++;
      $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
      $display("test done: total=%0d bad=%0d", checks, fails);
      $finish;
   end

endmodule